// File: doc/BRIEF.md
# USB Host Command, Status and Interrupt Core

This block holds the software-visible control state of a simple full-speed USB host controller. It has a command register that starts and stops frame processing and requests resets, suspend or resume. It has a status register with write-1-to-clear event bits and a halted indication, and an interrupt-enable register. It also keeps an 11-bit frame counter that advances on each frame tick while the controller runs. A 16-bit register port with a 2-bit select gives access to all of them. Reads are combinational.

The transfer engine reports interrupt causes through `cause_set` while it works through a frame: bit 0 is completion-with-interrupt and bit 1 is short packet. The core does not post these causes at once. It holds them until the next frame tick and then merges them into a readable cause field and raises the USB-interrupt status bit. A connect-change event from the root ports while global suspend is requested forces a resume and flags a resume-detect event. Two registered pulses carry reset requests out of the block. `ctl_rst_o` goes to the rest of the controller and `port_rst_o` drives a bus reset on every port.

Register map for `reg_sel`:
- 0: command. Bit 0 is run, bit 1 is controller reset, bit 2 is global reset, bit 3 is suspend request, bit 4 is forced resume.
- 1: status. Bit 0 is USB interrupt (W1C), bit 1 is resume detect (W1C), bit 2 is halted (read-only), bits 4:3 are the posted cause field (read-only; it clears together with bit 0).
- 2: interrupt enable. Bit 0 enables resume, bit 1 enables completion, bit 2 enables short packet.
- 3: frame number (read-only).

Top module: `usbh_cmd_status`

## Requirements
- R1: After reset, run is 0, halted is 1, the frame number is 0, no interrupt is requested, and status reads 0x0004.
- R2: A command write with bit 0 set while run is 0 clears halted on the next edge. A command write with bit 0 clear sets halted.
- R3: A frame tick while run is 1 advances the frame number by one, wrapping from 0x7FF to 0. `fl_index_o` equals its low 10 bits.
- R4: A frame tick while run is 0 leaves the frame number unchanged and sets halted.
- R5: Causes on `cause_set` gather during a frame and are not visible until the next running frame tick. At that tick they are ORed into status bits 4:3 and status bit 0 is set. Causes presented in the cycle of a tick belong to the following frame.
- R6: `irq_o` is (resume detect AND enable bit 0) OR (USB interrupt AND ((cause bit 3 AND enable bit 1) OR (cause bit 4 AND enable bit 2))).
- R7: Writing 1 to status bit 0 clears the USB-interrupt bit and the cause field. Writing 1 to bit 1 clears resume detect. Halted is unaffected by status writes.
- R8: A command write with bit 1 set returns every register and the frame number to the R1 values one edge later, ignores the other bits of that write, and pulses `ctl_rst_o` for one cycle without `port_rst_o`.
- R9: A command write with bit 2 set does everything R8 does and also pulses `port_rst_o` for one cycle. It takes priority when bits 1 and 2 are both set.
- R10: A connect event while command bit 3 is set sets command bit 4 and status bit 1. With bit 3 clear the event changes nothing.
- R11: Writes to the frame-number select leave the frame number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| cause_set | input | 2 | Interrupt causes found during the current frame |
| conn_evt | input | 1 | Port connect or disconnect event |
| irq_o | output | 1 | Level interrupt request |
| run_o | output | 1 | Run state |
| halted_o | output | 1 | Halted state |
| frame_o | output | 11 | Frame number |
| fl_index_o | output | 10 | Frame-list index |
| ctl_rst_o | output | 1 | Controller reset pulse |
| port_rst_o | output | 1 | Bus reset pulse toward the ports |

## Verification
The properties assume that `frame_tick` and `conn_evt` are single-cycle pulses, that register writes never collide with a reset request in a way that makes next-state checks ambiguous, and that the select only takes its four defined values. Each property that predicts a next state excludes cycles that carry a reset write. The stimulus applies each tick, event and write in its own low-clock phase, so no two stimuli race at an edge. Corner cases such as a cause arriving in the tick cycle are placed on purpose and are not left to chance.

// File: rtl/usbh_cmd_status.sv
module usbh_cmd_status #(
  parameter int FN_W  = 11,
  parameter int IDX_W = 10,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             frame_tick,
  input  logic [1:0]       cause_set,
  input  logic             conn_evt,
  output logic             irq_o,
  output logic             run_o,
  output logic             halted_o,
  output logic [FN_W-1:0]  frame_o,
  output logic [IDX_W-1:0] fl_index_o,
  output logic             ctl_rst_o,
  output logic             port_rst_o
);
  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_STS = 2'd1;
  localparam logic [1:0] SEL_IE  = 2'd2;
  localparam logic [1:0] SEL_FN  = 2'd3;

  logic            run_q, susp_q, fgr_q, halted_q, usbint_q, rd_q;
  logic [1:0]      cause_q, pend_q, cause_kept;
  logic [2:0]      ie_q;
  logic [FN_W-1:0] fn_q;
  logic            ctl_rst_q, port_rst_q;

  wire cmd_wr    = reg_wr && (reg_sel == SEL_CMD);
  wire sts_wr    = reg_wr && (reg_sel == SEL_STS);
  wire ie_wr     = reg_wr && (reg_sel == SEL_IE);
  wire glob_res  = cmd_wr && reg_wdata[2];
  wire any_res   = cmd_wr && (reg_wdata[1] || reg_wdata[2]);
  wire post      = frame_tick && run_q;
  wire stop_tick = frame_tick && !run_q;
  wire clr_int   = sts_wr && reg_wdata[0];
  wire clr_rd    = sts_wr && reg_wdata[1];

  assign cause_kept = clr_int ? 2'b00 : cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; susp_q <= 1'b0; fgr_q <= 1'b0; halted_q <= 1'b1;
      usbint_q <= 1'b0; rd_q <= 1'b0; cause_q <= '0; pend_q <= '0;
      ie_q <= '0; fn_q <= '0; ctl_rst_q <= 1'b0; port_rst_q <= 1'b0;
    end else begin
      ctl_rst_q  <= any_res;
      port_rst_q <= glob_res;
      if (any_res) begin
        run_q <= 1'b0; susp_q <= 1'b0; fgr_q <= 1'b0; halted_q <= 1'b1;
        usbint_q <= 1'b0; rd_q <= 1'b0; cause_q <= '0; pend_q <= '0;
        ie_q <= '0; fn_q <= '0;
      end else begin
        if (stop_tick) halted_q <= 1'b1;
        if (cmd_wr) begin
          run_q  <= reg_wdata[0];
          susp_q <= reg_wdata[3];
          fgr_q  <= reg_wdata[4];
          if (reg_wdata[0] && !run_q) halted_q <= 1'b0;
          else if (!reg_wdata[0])     halted_q <= 1'b1;
        end
        if (ie_wr) ie_q <= reg_wdata[2:0];
        if (post) begin
          fn_q   <= fn_q + 1'b1;
          pend_q <= cause_set;
        end else begin
          pend_q <= pend_q | cause_set;
        end
        if (post && (pend_q != 2'b00)) begin
          usbint_q <= 1'b1;
          cause_q  <= cause_kept | pend_q;
        end else begin
          if (clr_int) usbint_q <= 1'b0;
          cause_q <= cause_kept;
        end
        if (conn_evt && susp_q) begin
          rd_q  <= 1'b1;
          fgr_q <= 1'b1;
        end else if (clr_rd) begin
          rd_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CMD: reg_rdata = {{(DW-5){1'b0}}, fgr_q, susp_q, 2'b00, run_q};
      SEL_STS: reg_rdata = {{(DW-5){1'b0}}, cause_q, halted_q, rd_q, usbint_q};
      SEL_IE:  reg_rdata = {{(DW-3){1'b0}}, ie_q};
      default: reg_rdata = {{(DW-FN_W){1'b0}}, fn_q};
    endcase
  end

  assign irq_o      = (rd_q & ie_q[0]) | (usbint_q & |(cause_q & ie_q[2:1]));
  assign run_o      = run_q;
  assign halted_o   = halted_q;
  assign frame_o    = fn_q;
  assign fl_index_o = fn_q[IDX_W-1:0];
  assign ctl_rst_o  = ctl_rst_q;
  assign port_rst_o = port_rst_q;
endmodule

// File: rtl/usbh_cmd_status_chk.sv
module usbh_cmd_status_chk #(
  parameter int FN_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_sel,
  input logic [15:0]     reg_wdata,
  input logic            frame_tick,
  input logic            conn_evt,
  input logic            irq_o,
  input logic            run_o,
  input logic            halted_o,
  input logic [FN_W-1:0] frame_o,
  input logic            ctl_rst_o,
  input logic            port_rst_o,
  input logic            susp_q,
  input logic            fgr_q,
  input logic            rd_q,
  input logic            usbint_q
);
  wire res_wr = reg_wr && (reg_sel == 2'd0) && (reg_wdata[1] || reg_wdata[2]);
  wire cmd_wr = reg_wr && (reg_sel == 2'd0);

  p_frame_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && run_o && !res_wr) |=> (frame_o == $past(frame_o) + 1'b1));

  p_stop_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !run_o && !res_wr && !cmd_wr) |=> ($stable(frame_o) && halted_o));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !res_wr && reg_wdata[0] && !run_o) |=> (!halted_o && run_o));

  p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> (frame_o == '0 && halted_o && !run_o && !irq_o && ctl_rst_o));

  p_pulse_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rst_o && !res_wr) |=> !ctl_rst_o);

  p_port_with_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_o |-> ctl_rst_o);

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (usbint_q || rd_q));

  p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_evt && susp_q && !res_wr) |=> (rd_q && fgr_q));
endmodule

bind usbh_cmd_status usbh_cmd_status_chk #(.FN_W(FN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .frame_tick(frame_tick), .conn_evt(conn_evt),
  .irq_o(irq_o), .run_o(run_o), .halted_o(halted_o), .frame_o(frame_o),
  .ctl_rst_o(ctl_rst_o), .port_rst_o(port_rst_o), .susp_q(susp_q),
  .fgr_q(fgr_q), .rd_q(rd_q), .usbint_q(usbint_q)
);

// File: tb/tb_usbh_cmd_status.sv
module tb_usbh_cmd_status;
  localparam int PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, frame_tick = 1'b0, conn_evt = 1'b0;
  logic [1:0]  reg_sel = 2'd0, cause_set = 2'b00;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic        irq_o, run_o, halted_o, ctl_rst_o, port_rst_o;
  logic [10:0] frame_o;
  logic [9:0]  fl_index_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  usbh_cmd_status dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .cause_set(cause_set), .conn_evt(conn_evt), .irq_o(irq_o), .run_o(run_o),
    .halted_o(halted_o), .frame_o(frame_o), .fl_index_o(fl_index_o),
    .ctl_rst_o(ctl_rst_o), .port_rst_o(port_rst_o)
  );

  // {wr, sel, wdata, tick, cause, evt, chk_sel, expected, exp_irq, req}
  localparam logic [45:0] VEC [NV] = '{
    {1'b1,2'd2,16'h0007,1'b0,2'b00,1'b0,2'd2,16'h0007,1'b0,4'd6},  // R6 enables
    {1'b1,2'd0,16'h0001,1'b0,2'b00,1'b0,2'd1,16'h0000,1'b0,4'd2},  // R2 start
    {1'b0,2'd0,16'h0000,1'b0,2'b01,1'b0,2'd1,16'h0000,1'b0,4'd5},  // R5 held
    {1'b0,2'd0,16'h0000,1'b1,2'b00,1'b0,2'd1,16'h0009,1'b1,4'd5},  // R5 posted
    {1'b0,2'd0,16'h0000,1'b0,2'b00,1'b0,2'd3,16'h0001,1'b1,4'd3},  // R3 count
    {1'b1,2'd1,16'h0001,1'b0,2'b00,1'b0,2'd1,16'h0000,1'b0,4'd7},  // R7 clear
    {1'b0,2'd0,16'h0000,1'b1,2'b10,1'b0,2'd1,16'h0000,1'b0,4'd5},  // R5 tick-cycle cause
    {1'b0,2'd0,16'h0000,1'b1,2'b00,1'b0,2'd1,16'h0011,1'b1,4'd5},  // R5 next frame
    {1'b1,2'd2,16'h0003,1'b0,2'b00,1'b0,2'd2,16'h0003,1'b0,4'd6},  // R6 masked
    {1'b1,2'd1,16'h0001,1'b0,2'b00,1'b0,2'd3,16'h0003,1'b0,4'd7},  // R7
    {1'b1,2'd0,16'h0009,1'b0,2'b00,1'b0,2'd0,16'h0009,1'b0,4'd10}, // R10 suspend
    {1'b0,2'd0,16'h0000,1'b0,2'b00,1'b1,2'd0,16'h0019,1'b1,4'd10}, // R10 resume
    {1'b0,2'd0,16'h0000,1'b0,2'b00,1'b0,2'd1,16'h0002,1'b1,4'd10}, // R10 detect
    {1'b1,2'd1,16'h0002,1'b0,2'b00,1'b0,2'd1,16'h0000,1'b0,4'd7},  // R7 rd clear
    {1'b1,2'd0,16'h0000,1'b0,2'b00,1'b0,2'd1,16'h0004,1'b0,4'd2},  // R2 stop
    {1'b0,2'd0,16'h0000,1'b1,2'b00,1'b0,2'd3,16'h0003,1'b0,4'd4},  // R4
    {1'b0,2'd0,16'h0000,1'b0,2'b00,1'b1,2'd1,16'h0004,1'b0,4'd10}, // R10 no suspend
    {1'b1,2'd3,16'h0123,1'b0,2'b00,1'b0,2'd3,16'h0003,1'b0,4'd11}  // R11
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [1:0] sel, logic [15:0] exp);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 2'd1, 16'h0004);
    check("R1", {12'h0, run_o, halted_o, irq_o, 1'b0}, 16'h0004);
    rd_chk("R1", 2'd3, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      reg_wr = v[45]; reg_sel = v[44:43]; reg_wdata = v[42:27];
      frame_tick = v[26]; cause_set = v[25:24]; conn_evt = v[23];
      @(negedge clk);
      reg_wr = 1'b0; frame_tick = 1'b0; cause_set = 2'b00; conn_evt = 1'b0;
      rd_chk($sformatf("R%0d row %0d", v[3:0], i), v[22:21], v[20:5]);
      check($sformatf("R%0d row %0d irq", v[3:0], i), {15'h0, irq_o}, {15'h0, v[4]});
    end

    // R8 controller reset, run bit in the same write ignored
    wr(2'd0, 16'h0003);
    check("R8 ctl pulse", {14'h0, ctl_rst_o, port_rst_o}, 16'h0002);
    rd_chk("R8 cmd", 2'd0, 16'h0000);
    rd_chk("R8 sts", 2'd1, 16'h0004);
    rd_chk("R8 frame", 2'd3, 16'h0000);
    rd_chk("R8 ie", 2'd2, 16'h0000);
    @(negedge clk);
    check("R8 pulse end", {15'h0, ctl_rst_o}, 16'h0000);

    // R3 wrap
    wr(2'd0, 16'h0001);
    check("R2 run pin", {14'h0, run_o, halted_o}, 16'h0002);
    for (int k = 0; k < 2047; k++) tick();
    check("R3 frame max", {5'h0, frame_o}, 16'h07FF);
    check("R3 index", {6'h0, fl_index_o}, 16'h03FF);
    tick();
    check("R3 wrap", {5'h0, frame_o}, 16'h0000);
    tick(); tick();

    // R9 global reset takes priority
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0006);
    check("R9 pulses", {14'h0, ctl_rst_o, port_rst_o}, 16'h0003);
    rd_chk("R9 frame", 2'd3, 16'h0000);
    rd_chk("R9 sts", 2'd1, 16'h0004);
    rd_chk("R9 ie", 2'd2, 16'h0000);
    @(negedge clk);
    check("R9 pulse end", {14'h0, ctl_rst_o, port_rst_o}, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule